// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block turns a 32768 Hz timebase into a periodic event whose rate is picked by a 4-bit rate code. The timebase arrives as a one-cycle `tick` enable in the system clock domain. Every tick advances a free-running 15-bit count. An event fires on the tick that brings the low bits of that count to zero. How many low bits take part depends on the rate code.

Each event can do two things. It can pulse the periodic-interrupt strobe, which a neighbouring status register uses to set its flag. It can also pulse the square-wave output. Each output has its own enable. The square-wave output is a single-cycle pulse per event, not a waveform with 50 % duty.

Rate code 0 stops the divider. Codes 1 and 2 stand in for the slower codes 8 and 9. Events are aligned to the free-running count, not to the moment the rate code changes. A new code takes effect on the very next tick.

Top module: `periodic_irq_divider`

## Requirements
- R1: After reset both outputs are low and the free-running count is zero, so with rate code 3 the first event comes on exactly the 4th tick. The count advances by one on every tick and holds otherwise.
- R2: With rate code 0 neither output ever pulses, whatever the enables are.
- R3: For an effective code c in 3..15, events come every 2^(c-1) ticks. Any run of exactly 2^(c-1) consecutive ticks contains exactly one event.
- R4: Rate code 1 behaves exactly as code 8 (128 ticks). Rate code 2 behaves exactly as code 9 (256 ticks).
- R5: An event fires on the tick that makes the free-running count a multiple of the period, not a fixed number of ticks after a rate change.
- R6: `pf_strobe` pulses for an event only if `pie_en` is set. `sqw_pulse` pulses only if `sqw_en` is set. When both are set, both pulse in the same cycle.
- R7: Each output is high for one clock only, in the cycle right after the tick that caused it. Neither output is ever high in a cycle that does not follow a tick.
- R8: While both enables are low, the divider is stopped and nothing is held pending. A period boundary crossed while stopped produces no event after re-enabling; the next event is at the next boundary.
- R9: A change of rate code is used from the very next tick, with no extra latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable at the 32768 Hz timebase rate |
| rate_code | input | 4 | Rate select; 0 stops the divider, 1 and 2 alias to 8 and 9 |
| pie_en | input | 1 | Periodic-interrupt enable |
| sqw_en | input | 1 | Square-wave pulse enable |
| pf_strobe | output | 1 | One-cycle periodic-interrupt strobe |
| sqw_pulse | output | 1 | One-cycle square-wave pulse |

## Verification
The periodic strobe and the square-wave pulse come from the same event, so they can land in the same clock cycle. The bench sets both enables with the fastest rate code. It counts the cycles where both outputs are high and compares that count with the number of events the requirements predict. It also runs each enable alone and checks that the other output stays quiet in every cycle.

// File: rtl/pid_pkg.sv
`timescale 1ns/1ps
package pid_pkg;
  localparam int RATE_W      = 4;
  localparam int ALIAS_SHIFT = 7;

  typedef logic [RATE_W-1:0] rate_t;

  // Map the two fast-looking codes onto the slower rates they stand for.
  function automatic rate_t eff_code(input rate_t code);
    if (code == rate_t'(1) || code == rate_t'(2))
      return code + rate_t'(ALIAS_SHIFT);
    return code;
  endfunction

  // Number of low count bits that must roll to zero for an event.
  function automatic rate_t roll_bits(input rate_t code);
    rate_t e;
    e = eff_code(code);
    if (e == '0)
      return '0;
    return e - rate_t'(1);
  endfunction
endpackage

// File: rtl/pid_rate_decode.sv
`timescale 1ns/1ps
module pid_rate_decode #(
  parameter int CNT_W = 15
) (
  input  logic [pid_pkg::RATE_W-1:0] rate_code,
  output logic                       code_live,
  output logic [CNT_W-1:0]           roll_mask
);
  import pid_pkg::*;

  rate_t shift;

  assign code_live = (rate_code != '0);
  assign shift     = roll_bits(rate_code);

  // Thermometer mask of the low bits that define a period boundary.
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign roll_mask[i] = code_live && (i < int'(shift));
  end
endmodule

// File: rtl/pid_tb_counter.sv
`timescale 1ns/1ps
module pid_tb_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_next
);
  assign cnt_next = cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (tick)
      cnt <= cnt_next;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == $past(cnt) + CNT_W'(1)));  // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));  // R1
endmodule

// File: rtl/pid_event_gate.sv
`timescale 1ns/1ps
module pid_event_gate #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             code_live,
  input  logic [CNT_W-1:0] roll_mask,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic             pie_en,
  input  logic             sqw_en,
  output logic             evt_fire,
  output logic             pf_strobe,
  output logic             sqw_pulse
);
  logic div_run;
  logic boundary;

  assign div_run  = code_live && (pie_en || sqw_en);
  assign boundary = ((cnt_next & roll_mask) == '0);
  assign evt_fire = tick && div_run && boundary;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_strobe <= 1'b0;
      sqw_pulse <= 1'b0;
    end else begin
      pf_strobe <= evt_fire && pie_en;
      sqw_pulse <= evt_fire && sqw_en;
    end
  end

  AST_PIE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_strobe |-> $past(pie_en));  // R6
  AST_SQW_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_pulse |-> $past(sqw_en));  // R6
  AST_PF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_strobe |=> !pf_strobe);  // R7
  AST_SQW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_pulse |=> !sqw_pulse);  // R7
  AST_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_strobe || sqw_pulse) |-> $past(tick));  // R7
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !code_live |=> !(pf_strobe || sqw_pulse));  // R2
endmodule

// File: rtl/periodic_irq_divider.sv
`timescale 1ns/1ps
module periodic_irq_divider #(
  parameter int CNT_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] rate_code,
  input  logic       pie_en,
  input  logic       sqw_en,
  output logic       pf_strobe,
  output logic       sqw_pulse
);
  logic             code_live;
  logic [CNT_W-1:0] roll_mask;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_next;
  logic             evt_fire;

  pid_rate_decode #(.CNT_W(CNT_W)) u_decode (
    .rate_code (rate_code),
    .code_live (code_live),
    .roll_mask (roll_mask)
  );

  pid_tb_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cnt      (cnt),
    .cnt_next (cnt_next)
  );

  pid_event_gate #(.CNT_W(CNT_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .code_live (code_live),
    .roll_mask (roll_mask),
    .cnt_next  (cnt_next),
    .pie_en    (pie_en),
    .sqw_en    (sqw_en),
    .evt_fire  (evt_fire),
    .pf_strobe (pf_strobe),
    .sqw_pulse (sqw_pulse)
  );

  AST_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fire |=> ((cnt & $past(roll_mask)) == '0));  // R5
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(pie_en || sqw_en) |=> !(pf_strobe || sqw_pulse));  // R8
endmodule

// File: tb/periodic_irq_divider_test.sv
`timescale 1ns/1ps
module periodic_irq_divider_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       pie_en = 1'b0;
  logic       sqw_en = 1'b0;
  logic       pf_strobe;
  logic       sqw_pulse;

  int n_tests = 0;
  int n_fail  = 0;

  // bench reference state
  int mcnt = 0;
  int mism = 0;
  int pf_seen = 0;
  int sq_seen = 0;
  int both_seen = 0;
  int exp_events = 0;
  int idle_out = 0;

  always #5 clk = ~clk;

  periodic_irq_divider uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rate_code(rate_code),
    .pie_en(pie_en), .sqw_en(sqw_en),
    .pf_strobe(pf_strobe), .sqw_pulse(sqw_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int period_of(input int c);
    int e;
    e = (c == 1) ? 8 : (c == 2) ? 9 : c;
    return 1 << (e - 1);
  endfunction

  task automatic clear_stats();
    mism = 0; pf_seen = 0; sq_seen = 0; both_seen = 0;
    exp_events = 0; idle_out = 0;
  endtask

  // One clock: drive tick, predict, then compare away from the edge.
  task automatic cyc(input logic t);
    bit fire;
    bit ep, es;
    tick = t;
    @(posedge clk);
    fire = 1'b0;
    if (t) begin
      fire = (rate_code != 0) && (pie_en || sqw_en) &&
             (((mcnt + 1) % period_of(int'(rate_code))) == 0);
      mcnt = (mcnt + 1) % 32768;
    end
    ep = fire && pie_en;
    es = fire && sqw_en;
    if (fire) exp_events++;
    @(negedge clk);
    if (pf_strobe !== ep || sqw_pulse !== es) mism++;
    if (pf_strobe === 1'b1) pf_seen++;
    if (sqw_pulse === 1'b1) sq_seen++;
    if (pf_strobe === 1'b1 && sqw_pulse === 1'b1) both_seen++;
    if (!t && (pf_strobe === 1'b1 || sqw_pulse === 1'b1)) idle_out++;
  endtask

  task automatic run_ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1);
      for (int g = 0; g < gap; g++) cyc(1'b0);
    end
  endtask

  task automatic ticks_to_event(output int n);
    n = 0;
    for (int i = 0; i < 40000; i++) begin
      cyc(1'b1);
      n++;
      if (pf_strobe === 1'b1 || sqw_pulse === 1'b1) break;
    end
  endtask

  task automatic t_reset();
    int n;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset pf_strobe", int'(pf_strobe), 0);
    check("R1 reset sqw_pulse", int'(sqw_pulse), 0);
    rst_n = 1'b1;
    mcnt = 0;
    rate_code = 4'd3; pie_en = 1'b1; sqw_en = 1'b0;
    clear_stats();
    ticks_to_event(n);
    check("R1 first event tick", n, 4);
    check("R1 model match", mism, 0);
  endtask

  task automatic t_code_zero();
    rate_code = 4'd0; pie_en = 1'b1; sqw_en = 1'b1;
    clear_stats();
    run_ticks(300, 1);
    check("R2 pf with code 0", pf_seen, 0);
    check("R2 sqw with code 0", sq_seen, 0);
    check("R2 model match", mism, 0);
  endtask

  task automatic t_periods();
    pie_en = 1'b1; sqw_en = 1'b0;
    for (int c = 3; c <= 15; c++) begin
      rate_code = 4'(c);
      clear_stats();
      run_ticks(period_of(c), 0);
      check($sformatf("R3 one event per window code %0d", c), pf_seen, 1);
      check($sformatf("R3 model match code %0d", c), mism, 0);
    end
  endtask

  task automatic t_alias();
    int n;
    pie_en = 1'b1; sqw_en = 1'b0;
    rate_code = 4'd1;
    ticks_to_event(n);
    clear_stats();
    ticks_to_event(n);
    check("R4 code 1 spacing", n, 128);
    rate_code = 4'd2;
    ticks_to_event(n);
    ticks_to_event(n);
    check("R4 code 2 spacing", n, 256);
    check("R4 model match", mism, 0);
  endtask

  task automatic t_align();
    int n;
    pie_en = 1'b1; sqw_en = 1'b0;
    rate_code = 4'd6;
    ticks_to_event(n);            // count now a multiple of 32
    clear_stats();
    run_ticks(3, 0);              // count = 3 mod 32
    rate_code = 4'd3;
    ticks_to_event(n);
    check("R9 new code used on next tick", n, 1);
    rate_code = 4'd5;             // count = 4 mod 32
    ticks_to_event(n);
    check("R5 aligned to multiple of 16", n, 12);
    check("R5 model match", mism, 0);
  endtask

  task automatic t_gating();
    rate_code = 4'd3;
    pie_en = 1'b1; sqw_en = 1'b0;
    clear_stats();
    run_ticks(8, 0);
    check("R6 pie only pf count", pf_seen, 2);
    check("R6 pie only sqw count", sq_seen, 0);
    pie_en = 1'b0; sqw_en = 1'b1;
    clear_stats();
    run_ticks(8, 0);
    check("R6 sqw only pf count", pf_seen, 0);
    check("R6 sqw only sqw count", sq_seen, 2);
    pie_en = 1'b1; sqw_en = 1'b1;
    clear_stats();
    run_ticks(8, 0);
    check("R6 coincident pulses", both_seen, exp_events);
    check("R6 coincident count", both_seen, 2);
    check("R6 model match", mism, 0);
  endtask

  task automatic t_width();
    rate_code = 4'd3; pie_en = 1'b1; sqw_en = 1'b1;
    clear_stats();
    run_ticks(40, 3);
    check("R7 no output on idle cycles", idle_out, 0);
    check("R7 pulse count", pf_seen, 10);
    check("R7 model match", mism, 0);
  endtask

  task automatic t_no_pending();
    int n;
    rate_code = 4'd3; pie_en = 1'b1; sqw_en = 1'b0;
    ticks_to_event(n);            // count = 0 mod 4
    run_ticks(3, 0);              // count = 3 mod 4
    pie_en = 1'b0;
    clear_stats();
    run_ticks(1, 2);              // boundary crossed while stopped
    pie_en = 1'b1;
    run_ticks(1, 2);              // count = 1 mod 4
    check("R8 nothing pending after re-enable", pf_seen, 0);
    ticks_to_event(n);
    check("R8 next event at next boundary", n, 3);
    check("R8 model match", mism, 0);
  endtask

  initial begin
    #(10ns * 190000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_code_zero();
    t_periods();
    t_alias();
    t_align();
    t_gating();
    t_width();
    t_no_pending();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule